// File: doc/BRIEF.md
# Prescaled Down-Counting Interval Timer

This block is one timer channel. Software loads a starting count and sets a control word. While enabled, the channel lowers its count by one every (divider + 1) clock cycles. When the count runs out, the channel raises an expiry flag. In periodic mode it then reloads the starting count and keeps running. In one-shot mode it stops and turns off its own enable. The interrupt line is high while both the interrupt enable and the expiry flag are set. A separate pulse input clears the flag.

Software reaches the channel through a plain 32-bit register port. Writes take effect at the clock edge. Reads are combinational from a read address. The registers are:

- Address 0: the control word.
- Address 1: the starting count.
- Address 2: the live count.
- Address 3: unmapped.

The control word has these fields:

| Bit(s) | Field |
|---|---|
| 30 | run |
| 29 | interrupt enable |
| 27 | periodic |
| 26 | restart, self-clearing |
| 25 | running indicator, read-only |
| 7:0 | divider |

All other bits read as zero. The block has no data stream, so every pin is a plain control or status signal, with no valid/ready handshake.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control word reads 0x00000005 (divider 5, all flags clear), the starting count and live count read 0, and the expiry flag and interrupt are low.
- R2: Bits 31, 28, 26 and 24:8 of a control write are discarded; they always read back as 0.
- R3: Bit 25 (running indicator) ignores writes; it becomes 1 when run goes 0 to 1 and 0 when run goes 1 to 0, including the automatic stop in one-shot mode.
- R4: While run is set, the live count drops by one every (bits 7:0 + 1) cycles. A cycle that writes address 0 or 1 does not count. A rise of run, or a change of divider, restarts the divider phase at zero.
- R5: The tick that finds the live count at 1 or 0 sets the expiry flag. In one-shot mode (bit 27 = 0) it also leaves the count at 0 and clears run and the running indicator.
- R6: In periodic mode (bit 27 = 1) an expiry reloads the live count from the starting count and counting continues, so the flag recurs every N*(P+1) cycles.
- R7: A control write with bit 26 set reloads the live count from the starting count. A run bit set in the same write is dropped, and bit 26 never reads back as 1.
- R8: The interrupt output equals interrupt enable AND expiry flag, and follows a change of either at once. A one-cycle pulse on flag_clr clears the flag.
- R9: Writing address 1 sets the starting count and loads the live count with it at once; run keeps its previous value.
- R10: Clearing run freezes the live count; setting run again resumes from the frozen value.
- R11: Changing the divider keeps the present live count; the new ratio applies only to later decrements.
- R12: Writes to address 2 and address 3 change nothing; address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Combinational read data |
| flag_clr | input | 1 | Pulse to clear the expiry flag |
| flag_o | output | 1 | Expiry flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong divider phase or decrement shows at the live-count readout within one divider period. It also moves the expiry flag by a whole number of cycles, so the bench measures the edge-exact cycle at which the flag rises. A running indicator or run bit left stale after a one-shot expiry shows on the control readout in the cycle right after the expiry. A reload that takes the wrong value shows in the count read taken one nanosecond after the expiry edge, or in the next period's length.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W   = 32;
  localparam int PSC_W   = 8;
  localparam int ADDR_W  = 2;
  localparam int BIT_RUN = 30;
  localparam int BIT_IE  = 29;
  localparam int BIT_PER = 27;
  localparam int BIT_RLD = 26;
  localparam int BIT_ACT = 25;
  localparam logic [PSC_W-1:0] PSC_RESET = PSC_W'(5);

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_START = 2'd1,
    A_LIVE = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic             run;
    logic             ie;
    logic             per;
    logic             act;
    logic [PSC_W-1:0] psc;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  assign tick = run && (phase_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart || tick) begin
      phase_q <= '0;
    end else if (run) begin
      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             reload,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] live_q,
  output logic             expire
);
  assign expire = tick && (live_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else if (wr_start) begin
      start_q <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (wr_start) begin
      live_q <= wr_val;
    end else if (reload) begin
      live_q <= start_q;
    end else if (expire) begin
      live_q <= periodic ? start_q : '0;
    end else if (tick) begin
      live_q <= live_q - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             d_run,
  input  logic             d_ie,
  input  logic             d_per,
  input  logic             d_rld,
  input  logic [PSC_W-1:0] d_psc,
  input  logic             expire,
  input  logic             flag_clr,
  output ctrl_t            ctrl_q,
  output logic             flag_q,
  output logic             reload,
  output logic             phase_restart
);
  logic run_next;
  logic run_rise;
  logic run_fall;
  logic auto_stop;

  // A restart request in the same write vetoes the run bit.
  assign run_next      = d_run & ~d_rld;
  assign run_rise      = wr_ctrl & run_next & ~ctrl_q.run;
  assign run_fall      = wr_ctrl & ~run_next & ctrl_q.run;
  assign auto_stop     = expire & ~ctrl_q.per;
  assign reload        = wr_ctrl & d_rld;
  assign phase_restart = reload | run_rise | (wr_ctrl & (d_psc != ctrl_q.psc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.run <= 1'b0;
      ctrl_q.ie  <= 1'b0;
      ctrl_q.per <= 1'b0;
      ctrl_q.psc <= PSC_RESET;
    end else if (wr_ctrl) begin
      ctrl_q.run <= run_next;
      ctrl_q.ie  <= d_ie;
      ctrl_q.per <= d_per;
      ctrl_q.psc <= d_psc;
    end else if (auto_stop) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.act <= 1'b0;
    end else if (run_rise) begin
      ctrl_q.act <= 1'b1;
    end else if (run_fall || auto_stop) begin
      ctrl_q.act <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              flag_clr,
  output logic              flag_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic             wr_ctrl;
  logic             wr_start;
  logic             busy;
  logic             reload;
  logic             phase_restart;
  logic             tick;
  logic             expire;
  logic [REG_W-1:0] start_q;
  logic [REG_W-1:0] live_q;
  logic [REG_W-1:0] ctrl_word;
  logic             ch_run;
  logic             ch_act;
  logic             ch_per;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign wr_start = wr_en && (wr_addr == A_START);
  assign busy     = wr_ctrl | wr_start;
  assign ch_run   = ctrl_q.run;
  assign ch_act   = ctrl_q.act;
  assign ch_per   = ctrl_q.per;

  tmr_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ctrl       (wr_ctrl),
    .d_run         (wr_data[BIT_RUN]),
    .d_ie          (wr_data[BIT_IE]),
    .d_per         (wr_data[BIT_PER]),
    .d_rld         (wr_data[BIT_RLD]),
    .d_psc         (wr_data[PSC_W-1:0]),
    .expire        (expire),
    .flag_clr      (flag_clr),
    .ctrl_q        (ctrl_q),
    .flag_q        (flag_o),
    .reload        (reload),
    .phase_restart (phase_restart)
  );

  tmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.run & ~busy),
    .restart (phase_restart | wr_start),
    .div     (ctrl_q.psc),
    .tick    (tick)
  );

  tmr_count #(.CNT_W(REG_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_start (wr_start),
    .wr_val   (wr_data),
    .reload   (reload),
    .tick     (tick),
    .periodic (ctrl_q.per),
    .start_q  (start_q),
    .live_q   (live_q),
    .expire   (expire)
  );

  assign irq_o = ctrl_q.ie & flag_o;

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[BIT_RUN]     = ctrl_q.run;
    ctrl_word[BIT_IE]      = ctrl_q.ie;
    ctrl_word[BIT_PER]     = ctrl_q.per;
    ctrl_word[BIT_ACT]     = ctrl_q.act;
    ctrl_word[PSC_W-1:0]   = ctrl_q.psc;
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = ctrl_word;
      A_START: rd_data = start_q;
      A_LIVE:  rd_data = live_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ch_run,
  input logic             ch_act,
  input logic             ch_per,
  input logic             busy,
  input logic             expire,
  input logic             flag_o,
  input logic             flag_clr,
  input logic [CNT_W-1:0] live_q,
  input logic [CNT_W-1:0] start_q
);
  AST_ACT_TRACKS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ch_act == ch_run); // R3

  AST_ONE_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_run && !busy && !expire) |=>
      (live_q == $past(live_q) || live_q == $past(live_q) - CNT_W'(1))); // R4

  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ch_per) |=> (!ch_run && !ch_act && live_q == '0)); // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ch_per) |=> (live_q == $past(start_q))); // R6

  AST_FLAG_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(expire)); // R5

  AST_FLAG_CLEARED_BY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(flag_clr)); // R8

  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_run && !busy) |=> $stable(live_q)); // R10
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(tmr_pkg::REG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_run   (ch_run),
  .ch_act   (ch_act),
  .ch_per   (ch_per),
  .busy     (busy),
  .expire   (expire),
  .flag_o   (flag_o),
  .flag_clr (flag_clr),
  .live_q   (live_q),
  .start_q  (start_q)
);

// File: tb/test_tmr_channel.sv
`timescale 1ns/1ps
module test_tmr_channel;
  localparam logic [31:0] RUN  = 32'h4000_0000;
  localparam logic [31:0] IE   = 32'h2000_0000;
  localparam logic [31:0] PER  = 32'h0800_0000;
  localparam logic [31:0] RLD  = 32'h0400_0000;
  localparam logic [31:0] ACT  = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        flag_clr = 1'b0;
  logic        flag_o;
  logic        irq_o;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tmr_channel i_tmr_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_clr(flag_clr), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic clr;
    @(negedge clk); flag_clr = 1'b1;
    @(posedge clk); #1; flag_clr = 1'b0;
  endtask

  task automatic wait_flag(input int lim, output int c);
    c = 0;
    do begin @(posedge clk); #1; c++; end while (!flag_o && c < lim);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 control", v, 32'h0000_0005);
    rd(2'd1, v); chk("R1 start", v, 32'h0);
    rd(2'd2, v); chk("R1 live", v, 32'h0);
    chk("R1 flag", {31'b0, flag_o}, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_discard;
    logic [31:0] v;
    wr(2'd0, 32'h93FF_FF03);
    rd(2'd0, v); chk("R2 R3 discarded bits", v, 32'h0000_0003);
    wr(2'd2, 32'h0000_1234);
    rd(2'd2, v); chk("R12 live ignores write", v, 32'h0);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R12 addr3 reads 0", v, 32'h0);
    rd(2'd0, v); chk("R12 addr3 write no effect", v, 32'h0000_0003);
  endtask

  task automatic t_oneshot;
    logic [31:0] v; int c;
    wr(2'd1, 32'd4);
    rd(2'd2, v); chk("R9 load live", v, 32'd4);
    wr(2'd0, IE | RUN | 32'd2);
    rd(2'd0, v); chk("R3 act set on run", v, RUN | IE | ACT | 32'd2);
    wait_flag(100, c); chk("R4 expiry cycle", c, 32'd12);
    rd(2'd0, v); chk("R5 one-shot stop", v, IE | 32'd2);
    rd(2'd2, v); chk("R5 count zero", v, 32'd0);
    chk("R8 irq on", {31'b0, irq_o}, 32'd1);
  endtask

  task automatic t_irq;
    wr(2'd0, 32'd2);
    chk("R8 irq masked", {31'b0, irq_o}, 32'd0);
    chk("R8 flag kept", {31'b0, flag_o}, 32'd1);
    wr(2'd0, IE | 32'd2);
    chk("R8 irq unmasked", {31'b0, irq_o}, 32'd1);
    clr;
    chk("R8 flag cleared", {31'b0, flag_o}, 32'd0);
    chk("R8 irq cleared", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_periodic;
    logic [31:0] v; int c;
    wr(2'd1, 32'd3);
    wr(2'd0, RUN | PER);
    wait_flag(100, c); chk("R6 first period", c, 32'd3);
    rd(2'd2, v); chk("R6 reload", v, 32'd3);
    rd(2'd0, v); chk("R6 still running", v, RUN | PER | ACT);
    clr;
    wait_flag(100, c); chk("R6 second period", c, 32'd2);
    wr(2'd0, 32'd0);
    clr;
  endtask

  task automatic t_restart;
    logic [31:0] v;
    wr(2'd1, 32'd10);
    wr(2'd0, RUN);
    step(4);
    rd(2'd2, v); chk("R4 divide-by-1 count", v, 32'd6);
    wr(2'd0, RUN | RLD);
    rd(2'd0, v); chk("R7 run dropped", v, 32'd0);
    rd(2'd2, v); chk("R7 reloaded", v, 32'd10);
    step(3);
    rd(2'd2, v); chk("R7 stays stopped", v, 32'd10);
  endtask

  task automatic t_pause;
    logic [31:0] v;
    wr(2'd0, RUN | 32'd1);
    step(6);
    rd(2'd2, v); chk("R4 divide-by-2 count", v, 32'd7);
    wr(2'd0, 32'd1);
    rd(2'd2, v); chk("R10 frozen at stop", v, 32'd7);
    step(5);
    rd(2'd2, v); chk("R10 still frozen", v, 32'd7);
    wr(2'd0, RUN | 32'd1);
    step(4);
    rd(2'd2, v); chk("R10 resumed", v, 32'd5);
  endtask

  task automatic t_divider;
    logic [31:0] v; int c;
    wr(2'd0, RUN | 32'd3);
    rd(2'd2, v); chk("R11 count kept", v, 32'd5);
    step(4);
    rd(2'd2, v); chk("R11 new ratio", v, 32'd4);
    step(8);
    rd(2'd2, v); chk("R11 new ratio later", v, 32'd2);
    wait_flag(100, c); chk("R11 expiry cycle", c, 32'd8);
    rd(2'd0, v); chk("R5 stop after divider change", v, 32'd3);
    clr;
  endtask

  task automatic t_start_write;
    logic [31:0] v;
    wr(2'd1, 32'd20);
    rd(2'd2, v); chk("R9 load while stopped", v, 32'd20);
    rd(2'd0, v); chk("R9 run unchanged off", v, 32'd3);
    wr(2'd0, RUN);
    step(3);
    rd(2'd2, v); chk("R4 running", v, 32'd17);
    wr(2'd1, 32'd9);
    rd(2'd2, v); chk("R9 load while running", v, 32'd9);
    rd(2'd0, v); chk("R9 run unchanged on", v, RUN | ACT);
    step(2);
    rd(2'd2, v); chk("R9 continues", v, 32'd7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1);
    t_reset;
    t_discard;
    t_oneshot;
    t_irq;
    t_periodic;
    t_restart;
    t_pause;
    t_divider;
    t_start_write;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule